// File: doc/BRIEF.md
# Debounced Nibble-Scanning Change Detector

This block watches 32 digital input lines, grouped as four 8-bit ports, and keeps a filtered image of them. A sequencer walks the lines four at a time, one nibble per clock. It takes eight clocks to visit every line once. On each visit it compares every line of the nibble with the value it sampled on the previous visit. A new level is accepted only when it has been seen on a selectable number of consecutive visits. An accepted level that differs from the held image is written into the image. It also sets a sticky change flag for that line.

Software reads one port at a time through a combinational read mux. Pulsing a clear strobe together with the port select clears that port's change flags. A per-port nonzero flag on the change bits feeds interrupt logic. When `run` is dropped, the sequencer finishes the scan that is in progress and then halts. While halted, nothing in the image or the change flags moves, so all four ports can be read as one coherent snapshot. The block has no streaming data path. Every pin is a plain level or strobe, so there is no valid/ready handshake and no back-pressure.

Top module: `nibble_scan_detector`

## Requirements
- R1: While `rst_n` is low, each edge loads the image with `raw_in` and clears every change flag. After release, `halted` is low and scanning starts at nibble 0.
- R2: When not halted, exactly one nibble is visited per clock, in the order 0,1,...,7, and then the order wraps. Nibble k covers lines 4k..4k+3. An edge can alter image bits only inside the nibble visited on that edge.
- R3: A line's new level is accepted on the visit that is the T-th consecutive visit seeing that level, where T = DB_BASE << `db_sel`. With the defaults, `db_sel` values 0, 1, 2 and 3 give 1, 2, 4 and 8 visits.
- R4: With T of 2 or more, a line whose sampled level differs on every pair of consecutive visits is never accepted.
- R5: When an accepted level differs from the image, the image bit takes the new level and the line's change flag sets. Change flags never set on an edge that leaves the image bit unchanged.
- R6: A change flag stays set until an edge with `rd_clr` high and `rd_sel` naming its port. Flags of the other ports are unaffected, and a set on the same edge wins over the clear.
- R7: A low `run` never stops a scan part-way. `halted` rises only on the edge that visits nibble 7.
- R8: While `halted` is high, the image and change flags do not change. The edge that sees `run` high clears `halted`, and the next edge visits nibble 0.
- R9: `data_rd` and `chg_rd` show port `rd_sel` combinationally. Bit i of port p is line 8p+i.
- R10: `chg_any[p]` is high exactly when any change flag of port p is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_in | input | 32 | Raw input lines, already synchronised |
| db_sel | input | 2 | Debounce period select, T = DB_BASE << db_sel visits |
| run | input | 1 | High to scan, low to halt at the next scan end |
| rd_sel | input | 2 | Port selected for reading and clearing |
| rd_clr | input | 1 | Clears the change flags of the selected port on this edge |
| data_rd | output | 8 | Image of the selected port |
| chg_rd | output | 8 | Change flags of the selected port |
| chg_any | output | 4 | Per-port nonzero flag of the change flags |
| halted | output | 1 | High while the sequencer is stopped |

## Verification
A nibble is revisited every eight edges. After a line settles, its acceptance therefore lands between edge 8(T-1)+1 and edge 8T, counted from the negative edge at which the input was driven. The bench checks the old image at edge 8(T-1) and the new image at edge 8T, so the checks hold whatever the scan phase. A resume from halt fixes the phase exactly: the first edge clears `halted`, and edge 2+k visits nibble k. The stop-boundary and nibble-order checks therefore sample right after the edge for nibble 7, and between the edges for nibbles 4 and 5. A clear takes effect on the edge it is driven for, and the read mux is sampled 1 time unit after the inputs change.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
  // longest debounce period selectable, in visits
  function automatic int unsigned period_max(input int unsigned base, input int unsigned sel_w);
    return base << ((1 << sel_w) - 1);
  endfunction

  // bits needed to hold a run length up to maxv
  function automatic int unsigned cnt_bits(input int unsigned maxv);
    return $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/nsd_sequencer.sv
module nsd_sequencer #(
  parameter int NNIB  = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [PTR_W-1:0] ptr,
  output logic             halted,
  output logic [NNIB-1:0]  visit
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NNIB - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      halted <= 1'b0;
    end else if (halted) begin
      if (run) halted <= 1'b0;
    end else if (ptr == LAST) begin
      ptr    <= '0;
      halted <= !run;
    end else begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar n = 0; n < NNIB; n++) begin : g_visit
    assign visit[n] = !halted && (ptr == PTR_W'(n));
  end
endmodule

// File: rtl/nsd_nibble_filter.sv
module nsd_nibble_filter #(
  parameter int W     = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             visit,
  input  logic [W-1:0]     raw,
  input  logic [CNT_W-1:0] period,
  output logic [W-1:0]     img,
  output logic [W-1:0]     accept
);
  localparam logic [CNT_W-1:0] CSAT = '1;

  for (genvar i = 0; i < W; i++) begin : g_line
    logic             cand;
    logic [CNT_W-1:0] run_len_q;
    logic [CNT_W-1:0] run_len_d;

    always_comb begin
      if (raw[i] != cand)          run_len_d = CNT_W'(1);
      else if (run_len_q == CSAT)  run_len_d = CSAT;
      else                         run_len_d = run_len_q + 1'b1;
    end

    assign accept[i] = visit && (run_len_d >= period) && (raw[i] != img[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cand      <= raw[i];
        img[i]    <= raw[i];
        run_len_q <= '0;
      end else if (visit) begin
        cand      <= raw[i];
        run_len_q <= run_len_d;
        if (accept[i]) img[i] <= raw[i];
      end
    end
  end
endmodule

// File: rtl/nsd_change_bank.sv
module nsd_change_bank #(
  parameter int NPORT  = 4,
  parameter int PORT_W = 8,
  parameter int RSEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT*PORT_W-1:0] set_mask,
  input  logic                    rd_clr,
  input  logic [RSEL_W-1:0]       rd_sel,
  output logic [NPORT*PORT_W-1:0] chg,
  output logic [NPORT-1:0]        chg_any
);
  localparam int NCH = NPORT * PORT_W;

  logic [NCH-1:0] clr_mask;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign clr_mask[p*PORT_W +: PORT_W] = {PORT_W{rd_clr && (rd_sel == RSEL_W'(p))}};
    assign chg_any[p] = |chg[p*PORT_W +: PORT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chg <= '0;
    else        chg <= (chg & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/nibble_scan_detector.sv
module nibble_scan_detector #(
  parameter int NPORT    = 4,
  parameter int PORT_W   = 8,
  parameter int NIB_W    = 4,
  parameter int DB_SEL_W = 2,
  parameter int DB_BASE  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT*PORT_W-1:0]   raw_in,
  input  logic [DB_SEL_W-1:0]       db_sel,
  input  logic                      run,
  input  logic [$clog2(NPORT)-1:0]  rd_sel,
  input  logic                      rd_clr,
  output logic [PORT_W-1:0]         data_rd,
  output logic [PORT_W-1:0]         chg_rd,
  output logic [NPORT-1:0]          chg_any,
  output logic                      halted
);
  localparam int NCH    = NPORT * PORT_W;
  localparam int NNIB   = NCH / NIB_W;
  localparam int PTR_W  = $clog2(NNIB);
  localparam int RSEL_W = $clog2(NPORT);
  localparam int PMAX   = nsd_pkg::period_max(DB_BASE, DB_SEL_W);
  localparam int CNT_W  = nsd_pkg::cnt_bits(PMAX);

  logic [PTR_W-1:0] ptr;
  logic [NNIB-1:0]  visit;
  logic [NCH-1:0]   img_all;
  logic [NCH-1:0]   set_all;
  logic [NCH-1:0]   chg_all;
  logic [CNT_W-1:0] period;

  assign period = CNT_W'(DB_BASE) << db_sel;

  nsd_sequencer #(.NNIB(NNIB), .PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ptr(ptr), .halted(halted), .visit(visit)
  );

  for (genvar n = 0; n < NNIB; n++) begin : g_nib
    nsd_nibble_filter #(.W(NIB_W), .CNT_W(CNT_W)) u_flt (
      .clk(clk), .rst_n(rst_n), .visit(visit[n]),
      .raw(raw_in[n*NIB_W +: NIB_W]), .period(period),
      .img(img_all[n*NIB_W +: NIB_W]), .accept(set_all[n*NIB_W +: NIB_W])
    );
  end

  nsd_change_bank #(.NPORT(NPORT), .PORT_W(PORT_W), .RSEL_W(RSEL_W)) u_chg (
    .clk(clk), .rst_n(rst_n), .set_mask(set_all),
    .rd_clr(rd_clr), .rd_sel(rd_sel),
    .chg(chg_all), .chg_any(chg_any)
  );

  assign data_rd = img_all[rd_sel*PORT_W +: PORT_W];
  assign chg_rd  = chg_all[rd_sel*PORT_W +: PORT_W];
endmodule

// File: rtl/nsd_checker.sv
module nsd_checker #(
  parameter int NCH   = 32,
  parameter int NIB_W = 4,
  parameter int NNIB  = 8,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_clr,
  input logic             halted,
  input logic [PTR_W-1:0] ptr,
  input logic [NCH-1:0]   img,
  input logic [NCH-1:0]   chg
);
  localparam logic [NCH-1:0] NMASK = {{(NCH-NIB_W){1'b0}}, {NIB_W{1'b1}}};

  // R2: an edge only moves image bits of the nibble it visits
  p_one_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> ((img ^ $past(img)) & ~(NMASK << (NIB_W * $past(ptr)))) == '0);

  // R5: a change flag rises only together with a toggle of its image bit
  p_set_on_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg & ~$past(chg)) & ~(img ^ $past(img))) == '0);

  // R6: without a clear strobe no flag falls
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> (chg & $past(chg)) == $past(chg));

  // R7: the halt begins only after the last nibble of a scan
  p_halt_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(ptr) == PTR_W'(NNIB - 1));

  // R8: nothing is recorded while halted
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (img == $past(img)) && ((chg & ~$past(chg)) == '0));
endmodule

bind nibble_scan_detector nsd_checker #(
  .NCH(NCH), .NIB_W(NIB_W), .NNIB(NNIB), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_clr(rd_clr), .halted(halted),
  .ptr(ptr), .img(img_all), .chg(chg_all)
);

// File: tb/sim_nibble_scan_detector.sv
module sim_nibble_scan_detector;
  localparam int CLK_P = 10;
  localparam int NVEC  = 6;
  // {db_sel, raw}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 32'h5A3C_F069},
    {2'd1, 32'h5A3C_F06B},
    {2'd2, 32'h00C3_F06B},
    {2'd3, 32'hFFFF_FFFF},
    {2'd1, 32'h1234_5678},
    {2'd0, 32'h1234_5678}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] raw_in = 32'hA5C3_0F96;
  logic [1:0]  db_sel = 2'd0;
  logic        run = 1'b1;
  logic [1:0]  rd_sel = 2'd0;
  logic        rd_clr = 1'b0;
  logic [7:0]  data_rd, chg_rd;
  logic [3:0]  chg_any;
  logic        halted;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] exp_img, exp_chg;

  always #(CLK_P/2) clk = ~clk;

  nibble_scan_detector u0 (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .db_sel(db_sel), .run(run),
    .rd_sel(rd_sel), .rd_clr(rd_clr), .data_rd(data_rd), .chg_rd(chg_rd),
    .chg_any(chg_any), .halted(halted)
  );

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // read all ports and compare image, flags and nonzero flags (R9, R10)
  task automatic chk_all(input string tag, input logic [31:0] ei, input logic [31:0] ec);
    logic [31:0] gi, gc;
    logic [3:0]  ea;
    for (int p = 0; p < 4; p++) begin
      rd_sel = 2'(p);
      #1;
      gi[p*8 +: 8] = data_rd;
      gc[p*8 +: 8] = chg_rd;
      ea[p] = |ec[p*8 +: 8];
    end
    chk({tag, " image (R9)"}, gi, ei);
    chk({tag, " flags (R9)"}, gc, ec);
    chk({tag, " nonzero (R10)"}, {28'd0, chg_any}, {28'd0, ea});
  endtask

  task automatic clear_port(input int p);
    rd_sel = 2'(p);
    rd_clr = 1'b1;
    tick(1);
    rd_clr = 1'b0;
    exp_chg[p*8 +: 8] = 8'h00;
  endtask

  initial begin
    #(CLK_P * 200000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(3);
    rst_n = 1'b1;
    exp_img = raw_in;
    exp_chg = '0;
    // R1: reset state
    chk("R1 halted after reset", {31'd0, halted}, 32'd0);
    chk_all("R1 reset", exp_img, exp_chg);

    // table of vectors: R3 timing, R5 flags, R6 selective clear
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] nv;
      int t;
      nv = VEC[v][31:0];
      db_sel = VEC[v][33:32];
      t = 1 << VEC[v][33:32];
      raw_in = nv;
      if (t > 1) begin
        tick((t - 1) * 8);
        chk_all("R3 not yet accepted", exp_img, exp_chg);
        tick(8);
      end else begin
        tick(8);
      end
      exp_chg = exp_chg | (exp_img ^ nv);
      exp_img = nv;
      chk_all("R3 R5 accepted", exp_img, exp_chg);
      clear_port(0);
      chk_all("R6 port0 cleared only", exp_img, exp_chg);
      for (int p = 1; p < 4; p++) clear_port(p);
      chk_all("R6 all cleared", exp_img, exp_chg);
    end

    // R4: bounce synchronised to the scan never settles with T=2
    db_sel = 2'd1;
    for (int k = 0; k < 10; k++) begin
      raw_in[0] = ~raw_in[0];
      tick(8);
    end
    tick(24);
    chk_all("R4 bounce rejected", exp_img, exp_chg);

    // R7: stop waits for scan end
    run = 1'b0;
    tick(9);
    chk("R7 halted within a scan", {31'd0, halted}, 32'd1);
    run = 1'b1;
    tick(1);
    chk("R8 resume clears halted", {31'd0, halted}, 32'd0);
    tick(2);
    run = 1'b0;
    tick(5);
    chk("R7 no halt mid-scan", {31'd0, halted}, 32'd0);
    tick(1);
    chk("R7 halt after nibble 7", {31'd0, halted}, 32'd1);

    // R8: frozen while halted; R2 nibble order after resume
    db_sel = 2'd0;
    raw_in = raw_in ^ 32'h00FF_0000;
    tick(40);
    chk_all("R8 frozen", exp_img, exp_chg);
    run = 1'b1;
    tick(1);
    tick(5);
    rd_sel = 2'd2;
    #1;
    chk("R2 nibble 4 only", {24'd0, data_rd}, {24'd0, exp_img[23:20], raw_in[19:16]});
    tick(1);
    exp_chg = exp_chg | (exp_img ^ raw_in);
    exp_img = raw_in;
    chk_all("R2 R5 nibble 5 done", exp_img, exp_chg);
    clear_port(2);

    // R1: reset in operation reloads image and clears flags
    raw_in[0] = ~raw_in[0];
    tick(9);
    exp_chg[0] = 1'b1;
    exp_img = raw_in;
    chk_all("R5 flag before reset", exp_img, exp_chg);
    rst_n = 1'b0;
    raw_in = 32'hC001_D00D;
    tick(2);
    rst_n = 1'b1;
    chk_all("R1 reload", 32'hC001_D00D, 32'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule